// File: doc/BRIEF.md
# Out-of-Order Dispatch Window

This block sits between instruction fetch and the execution stage. It keeps a short window of up to four fetched instructions in program order and, every cycle, checks all of them at once against a per-register countdown scoreboard and against one another. It then sends out the oldest instruction that can start without stalling. A younger instruction may pass an older one that is waiting on a slow load. The younger one must not read a register that the older one will write, must not write a register that the older one writes, and must not write a register that the older one still has to read.

Each fetched instruction carries a destination register, two source registers and a flag that marks a load. When an instruction dispatches, the scoreboard records when its result becomes usable. An ALU result can be forwarded, so it is usable on the next cycle. A load result is usable only a fixed number of cycles later. A separate miss input lets the memory side extend the wait on one register when a load misses the cache. A flush input cancels everything the window holds after a taken or mispredicted branch.

Top module: `dispatch_window`

## Requirements
- R1: The window holds at most 4 instructions in program order. An instruction offered with `in_valid` high is stored when `stall` and `flush` are both low. The fill count never exceeds 4.
- R2: In each cycle without flush, `out_valid` is high when at least one held entry is eligible. The `out_*` fields then carry the oldest eligible entry. The entries left behind keep their relative order.
- R3: An entry is not eligible while either of its nonzero source registers has a pending countdown in the scoreboard.
- R4: Register 0 never blocks. A source of 0 is always ready, a destination of 0 creates no ordering hazard, and neither a dispatch nor a miss on register 0 sets a countdown.
- R5: If an instruction that writes register r dispatches in cycle t, a reader of r may dispatch from cycle t+2 when the writer is a load (`is_load`=1). It may dispatch from cycle t+1 when the writer is not a load.
- R6: A miss pulse (`miss_valid`=1) for register r in cycle t blocks every reader of r until cycle t+10. In that case it overrides a dispatch to r in the same cycle.
- R7: An entry whose nonzero destination equals the destination of an older held entry is not eligible (write-after-write).
- R8: An entry whose nonzero destination equals a source of an older held entry is not eligible (write-after-read).
- R9: An entry that reads the nonzero destination of an older held entry is not eligible (read-after-write within the window).
- R10: In a flush cycle `out_valid` is low and nothing dispatches. The window is empty on the next cycle, the instruction offered in that cycle is dropped, and every scoreboard countdown is cleared.
- R11: After reset `out_valid` and `stall` are low. `stall` is high exactly when 4 entries are held and no entry dispatches. In that case the offered instruction is dropped.
- R12: When the window is full and an entry dispatches, `stall` stays low and the offered instruction is stored in the same cycle, behind the remaining entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A fetched instruction is offered |
| in_rd | input | 3 | Destination register of the offered instruction |
| in_rs1 | input | 3 | First source register |
| in_rs2 | input | 3 | Second source register |
| in_is_load | input | 1 | Offered instruction is a load |
| miss_valid | input | 1 | Cache miss extends the wait on one register |
| miss_reg | input | 3 | Register whose result is delayed by the miss |
| flush | input | 1 | Cancel all held instructions |
| out_valid | output | 1 | An instruction dispatches this cycle |
| out_rd | output | 3 | Destination of the dispatched instruction |
| out_rs1 | output | 3 | First source of the dispatched instruction |
| out_rs2 | output | 3 | Second source of the dispatched instruction |
| out_is_load | output | 1 | Dispatched instruction is a load |
| stall | output | 1 | Window full and nothing dispatched; fetch must hold |

## Verification
The bench targets the following corner cases, and each one catches a particular fault:
- Load latency boundary: a reader is offered right behind a load. A countdown that is one cycle short lets the reader out on the cycle after the load. A countdown that is one cycle long holds it past the second cycle.
- Hazards against a blocked older entry: one younger entry either writes what the older one reads, writes what the older one writes, or reads what the older one writes. A selector that only checks the scoreboard would let that younger entry overtake.
- Register 0: a design that treats register 0 as an ordinary register stalls independent work.
- Full window: a dispatch in a full cycle must accept the new instruction at once. When nothing dispatches, the stall must drop the offered instruction rather than overwrite the tail.
- Flush: a flush with an instruction offered and a miss pending must leave nothing behind.

A long pseudo-random stream over a small set of registers then compares every cycle against an arithmetic model of the window.

// File: rtl/dq_pkg.sv
package dq_pkg;
    localparam int REG_W = 3;

    typedef struct packed {
        logic [REG_W-1:0] rd;
        logic [REG_W-1:0] rs1;
        logic [REG_W-1:0] rs2;
        logic             is_load;
    } dq_instr_t;
endpackage

// File: rtl/dq_scoreboard.sv
module dq_scoreboard
    import dq_pkg::*;
#(
    parameter int NREG     = 8,
    parameter int LOAD_LAT = 2,
    parameter int MISS_LAT = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             set_valid,
    input  logic [REG_W-1:0] set_reg,
    input  logic             set_load,
    input  logic             miss_valid,
    input  logic [REG_W-1:0] miss_reg,
    output logic [NREG-1:0]  busy
);
    localparam int CW = $clog2(MISS_LAT);

    for (genvar r = 0; r < NREG; r++) begin : g_reg
        if (r == 0) begin : g_zero
            // register 0 is hardwired: never pending
            assign busy[r] = 1'b0;
        end else begin : g_cnt
            logic [CW-1:0] left_q;
            always_ff @(posedge clk) begin
                if (!rst_n || flush) begin
                    left_q <= '0;
                end else if (miss_valid && miss_reg == REG_W'(r)) begin
                    left_q <= CW'(MISS_LAT - 1);
                end else if (set_valid && set_reg == REG_W'(r)) begin
                    left_q <= set_load ? CW'(LOAD_LAT - 1) : '0;
                end else if (left_q != '0) begin
                    left_q <= left_q - 1'b1;
                end
            end
            assign busy[r] = (left_q != '0);
        end
    end
endmodule

// File: rtl/dq_pick.sv
module dq_pick
    import dq_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int NREG  = 8,
    localparam int IW   = $clog2(DEPTH)
) (
    input  dq_instr_t        ent [DEPTH],
    input  logic [DEPTH-1:0] held,
    input  logic [NREG-1:0]  busy,
    input  logic             block,
    output logic             pick_valid,
    output logic [IW-1:0]    pick_idx
);
    logic [DEPTH-1:0] elig;

    always_comb begin
        logic ok;
        elig = '0;
        for (int i = 0; i < DEPTH; i++) begin
            ok = held[i] && !block;
            // scoreboard readiness of sources
            if (ent[i].rs1 != '0 && busy[ent[i].rs1]) ok = 1'b0;
            if (ent[i].rs2 != '0 && busy[ent[i].rs2]) ok = 1'b0;
            // ordering against older entries still waiting
            for (int j = 0; j < DEPTH; j++) begin
                if (j < i && held[j]) begin
                    if (ent[i].rd != '0 &&
                        (ent[i].rd == ent[j].rd ||
                         ent[i].rd == ent[j].rs1 ||
                         ent[i].rd == ent[j].rs2)) ok = 1'b0;
                    if (ent[i].rs1 != '0 && ent[i].rs1 == ent[j].rd) ok = 1'b0;
                    if (ent[i].rs2 != '0 && ent[i].rs2 == ent[j].rd) ok = 1'b0;
                end
            end
            elig[i] = ok;
        end
    end

    always_comb begin
        pick_valid = |elig;
        pick_idx   = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (elig[i]) pick_idx = IW'(i);
        end
    end
endmodule

// File: rtl/dispatch_window.sv
module dispatch_window
    import dq_pkg::*;
#(
    parameter int DEPTH    = 4,
    parameter int LOAD_LAT = 2,
    parameter int MISS_LAT = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [REG_W-1:0] in_rd,
    input  logic [REG_W-1:0] in_rs1,
    input  logic [REG_W-1:0] in_rs2,
    input  logic             in_is_load,
    input  logic             miss_valid,
    input  logic [REG_W-1:0] miss_reg,
    input  logic             flush,
    output logic             out_valid,
    output logic [REG_W-1:0] out_rd,
    output logic [REG_W-1:0] out_rs1,
    output logic [REG_W-1:0] out_rs2,
    output logic             out_is_load,
    output logic             stall
);
    localparam int NREG = 1 << REG_W;
    localparam int IW   = $clog2(DEPTH);
    localparam int CNTW = $clog2(DEPTH + 1);

    dq_instr_t        q     [DEPTH];
    dq_instr_t        q_n   [DEPTH];
    logic [CNTW-1:0]  cnt, cnt_n, rem;
    logic [DEPTH-1:0] held;
    logic [NREG-1:0]  busy;
    logic             pick_valid, accept;
    logic [IW-1:0]    pick_idx;
    dq_instr_t        in_instr, sel;

    assign in_instr = '{rd: in_rd, rs1: in_rs1, rs2: in_rs2, is_load: in_is_load};

    for (genvar k = 0; k < DEPTH; k++) begin : g_held
        assign held[k] = (CNTW'(k) < cnt);
    end

    dq_pick #(.DEPTH(DEPTH), .NREG(NREG)) u_pick (
        .ent       (q),
        .held      (held),
        .busy      (busy),
        .block     (flush),
        .pick_valid(pick_valid),
        .pick_idx  (pick_idx)
    );

    assign sel = q[pick_idx];

    dq_scoreboard #(.NREG(NREG), .LOAD_LAT(LOAD_LAT), .MISS_LAT(MISS_LAT)) u_sb (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .set_valid (pick_valid),
        .set_reg   (sel.rd),
        .set_load  (sel.is_load),
        .miss_valid(miss_valid),
        .miss_reg  (miss_reg),
        .busy      (busy)
    );

    // outputs
    always_comb begin
        out_valid   = pick_valid;
        out_rd      = pick_valid ? sel.rd      : '0;
        out_rs1     = pick_valid ? sel.rs1     : '0;
        out_rs2     = pick_valid ? sel.rs2     : '0;
        out_is_load = pick_valid && sel.is_load;
        stall       = (cnt == CNTW'(DEPTH)) && !pick_valid;
        accept      = in_valid && !stall && !flush;
    end

    // next window contents: close the gap, then append at the tail
    always_comb begin
        q_n = q;
        rem = cnt;
        if (pick_valid) begin
            for (int k = 0; k < DEPTH - 1; k++) begin
                if (IW'(k) >= pick_idx) q_n[k] = q[k+1];
            end
            rem = cnt - 1'b1;
        end
        for (int k = 0; k < DEPTH; k++) begin
            if (accept && CNTW'(k) == rem) q_n[k] = in_instr;
        end
        cnt_n = flush ? '0 : rem + CNTW'(accept);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            for (int k = 0; k < DEPTH; k++) q[k] <= '0;
        end else begin
            cnt <= cnt_n;
            q   <= q_n;
        end
    end
endmodule

// File: rtl/dispatch_window_chk.sv
module dispatch_window_chk #(
    parameter int DEPTH = 4,
    parameter int NREG  = 8,
    parameter int REG_W = 3,
    parameter int CNTW  = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             flush,
    input logic             out_valid,
    input logic [REG_W-1:0] out_rd,
    input logic [REG_W-1:0] out_rs1,
    input logic [REG_W-1:0] out_rs2,
    input logic             out_is_load,
    input logic             stall,
    input logic [NREG-1:0]  busy,
    input logic [CNTW-1:0]  cnt
);
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNTW'(DEPTH)); // R1
    AST_SRC1_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_rs1 != '0) |-> !busy[out_rs1]); // R3
    AST_SRC2_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_rs2 != '0) |-> !busy[out_rs2]); // R3
    AST_ZERO_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy[0]); // R4
    AST_LOAD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_is_load && out_rd != '0) |=>
        !(out_valid && (out_rs1 == $past(out_rd) || out_rs2 == $past(out_rd)))); // R5
    AST_FLUSH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> !out_valid); // R10
    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> cnt == '0); // R10
    AST_STALL_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (cnt == CNTW'(DEPTH) && !out_valid)); // R11
endmodule

bind dispatch_window dispatch_window_chk #(
    .DEPTH(DEPTH), .NREG(NREG), .REG_W(dq_pkg::REG_W), .CNTW(CNTW)
) u_chk (
    .clk(clk), .rst_n(rst_n), .flush(flush), .out_valid(out_valid),
    .out_rd(out_rd), .out_rs1(out_rs1), .out_rs2(out_rs2),
    .out_is_load(out_is_load), .stall(stall), .busy(busy), .cnt(cnt)
);

// File: tb/tb_dispatch_window.sv
module tb_dispatch_window;
    localparam int CLK_PERIOD = 10;
    localparam int LOAD_LAT   = 2;
    localparam int MISS_LAT   = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       in_valid, in_is_load, miss_valid, flush;
    logic [2:0] in_rd, in_rs1, in_rs2, miss_reg;
    logic       out_valid, out_is_load, stall;
    logic [2:0] out_rd, out_rs1, out_rs2;

    int total = 0;
    int bad   = 0;

    // window model
    logic [2:0] m_rd [4];
    logic [2:0] m_s1 [4];
    logic [2:0] m_s2 [4];
    logic       m_ld [4];
    int         m_cnt;
    int         m_sb [8];

    always #(CLK_PERIOD/2) clk = ~clk;

    dispatch_window dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_rd(in_rd),
        .in_rs1(in_rs1), .in_rs2(in_rs2), .in_is_load(in_is_load),
        .miss_valid(miss_valid), .miss_reg(miss_reg), .flush(flush),
        .out_valid(out_valid), .out_rd(out_rd), .out_rs1(out_rs1),
        .out_rs2(out_rs2), .out_is_load(out_is_load), .stall(stall)
    );

    function automatic bit m_elig(int i);
        if (m_s1[i] != 0 && m_sb[m_s1[i]] != 0) return 0;
        if (m_s2[i] != 0 && m_sb[m_s2[i]] != 0) return 0;
        for (int j = 0; j < i; j++) begin
            if (m_rd[i] != 0 && (m_rd[i] == m_rd[j] || m_rd[i] == m_s1[j] ||
                                 m_rd[i] == m_s2[j])) return 0;
            if (m_s1[i] != 0 && m_s1[i] == m_rd[j]) return 0;
            if (m_s2[i] != 0 && m_s2[i] == m_rd[j]) return 0;
        end
        return 1;
    endfunction

    task automatic step(input logic iv, input logic [2:0] rd, input logic [2:0] s1,
                        input logic [2:0] s2, input logic ld, input logic fl,
                        input logic mv, input logic [2:0] mr, input string tag);
        int  sel;
        bit  ev, est, acc;
        @(negedge clk);
        in_valid = iv; in_rd = rd; in_rs1 = s1; in_rs2 = s2; in_is_load = ld;
        flush = fl; miss_valid = mv; miss_reg = mr;
        #1;
        sel = -1;
        if (!fl) begin
            for (int i = 0; i < m_cnt; i++) if (sel < 0 && m_elig(i)) sel = i;
        end
        ev  = (sel >= 0);
        est = (m_cnt == 4) && !ev;
        total++;
        if (out_valid !== ev || stall !== est ||
            (ev && (out_rd !== m_rd[sel] || out_rs1 !== m_s1[sel] ||
                    out_rs2 !== m_s2[sel] || out_is_load !== m_ld[sel]))) begin
            bad++;
            $display("FAIL %s t=%0t: got v=%0d rd=%0d rs1=%0d rs2=%0d ld=%0d stall=%0d exp v=%0d rd=%0d rs1=%0d rs2=%0d ld=%0d stall=%0d",
                     tag, $time, out_valid, out_rd, out_rs1, out_rs2, out_is_load, stall,
                     ev, ev ? m_rd[sel] : 3'd0, ev ? m_s1[sel] : 3'd0,
                     ev ? m_s2[sel] : 3'd0, ev ? m_ld[sel] : 1'b0, est);
        end
        // advance model
        acc = iv && !est && !fl;
        for (int r = 1; r < 8; r++) if (m_sb[r] > 0) m_sb[r]--;
        if (ev && m_rd[sel] != 0) m_sb[m_rd[sel]] = m_ld[sel] ? LOAD_LAT - 1 : 0;
        if (mv && mr != 0) m_sb[mr] = MISS_LAT - 1;
        if (ev) begin
            for (int k = sel; k < 3; k++) begin
                m_rd[k] = m_rd[k+1]; m_s1[k] = m_s1[k+1];
                m_s2[k] = m_s2[k+1]; m_ld[k] = m_ld[k+1];
            end
            m_cnt--;
        end
        if (acc) begin
            m_rd[m_cnt] = rd; m_s1[m_cnt] = s1; m_s2[m_cnt] = s2; m_ld[m_cnt] = ld;
            m_cnt++;
        end
        if (fl) begin
            m_cnt = 0;
            for (int r = 0; r < 8; r++) m_sb[r] = 0;
        end
    endtask

    task automatic push(input logic [2:0] rd, input logic [2:0] s1,
                        input logic [2:0] s2, input logic ld, input string tag);
        step(1'b1, rd, s1, s2, ld, 1'b0, 1'b0, 3'd0, tag);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(1'b0, 0, 0, 0, 0, 1'b0, 1'b0, 3'd0, tag);
    endtask

    task automatic miss(input logic [2:0] r, input string tag);
        step(1'b0, 0, 0, 0, 0, 1'b0, 1'b1, r, tag);
    endtask

    task automatic do_flush(input string tag);
        step(1'b0, 0, 0, 0, 0, 1'b1, 1'b0, 3'd0, tag);
    endtask

    task automatic summary;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL R2 watchdog expired: got hung run, expected completion");
        summary();
    end

    initial begin
        logic [31:0] x;
        in_valid = 0; in_rd = 0; in_rs1 = 0; in_rs2 = 0; in_is_load = 0;
        flush = 0; miss_valid = 0; miss_reg = 0;
        m_cnt = 0;
        for (int r = 0; r < 8; r++) m_sb[r] = 0;
        rst_n = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        #1;
        total++;  // R11 reset state
        if (out_valid !== 1'b0 || stall !== 1'b0) begin
            bad++;
            $display("FAIL R11 reset: got v=%0d stall=%0d exp v=0 stall=0", out_valid, stall);
        end

        // R5: load-use gap of two cycles, ALU forwarding next cycle
        push(3'd1, 3'd2, 3'd0, 1'b1, "R5");
        push(3'd3, 3'd1, 3'd1, 1'b0, "R5");
        idle(3, "R5");
        push(3'd4, 3'd5, 3'd0, 1'b0, "R5");
        push(3'd6, 3'd4, 3'd0, 1'b0, "R5");
        idle(2, "R5");

        // R6 and R3: miss holds readers ten cycles
        miss(3'd2, "R6");
        push(3'd5, 3'd2, 3'd0, 1'b0, "R3");
        idle(10, "R6");

        // R7: write-after-write behind a blocked writer
        miss(3'd1, "R7");
        push(3'd2, 3'd1, 3'd0, 1'b0, "R7");
        push(3'd2, 3'd0, 3'd0, 1'b0, "R7");
        push(3'd3, 3'd0, 3'd0, 1'b0, "R7");
        idle(2, "R7");
        do_flush("R10");

        // R8: write-after-read
        miss(3'd1, "R8");
        push(3'd3, 3'd1, 3'd4, 1'b0, "R8");
        push(3'd4, 3'd0, 3'd0, 1'b0, "R8");
        idle(2, "R8");
        do_flush("R10");

        // R9: read-after-write inside the window
        miss(3'd1, "R9");
        push(3'd5, 3'd1, 3'd0, 1'b0, "R9");
        push(3'd6, 3'd5, 3'd0, 1'b0, "R9");
        push(3'd7, 3'd0, 3'd5, 1'b0, "R9");
        idle(2, "R9");
        do_flush("R10");

        // R4: register 0 never blocks
        miss(3'd0, "R4");
        push(3'd0, 3'd0, 3'd0, 1'b1, "R4");
        push(3'd0, 3'd0, 3'd0, 1'b0, "R4");
        miss(3'd1, "R4");
        push(3'd0, 3'd1, 3'd0, 1'b0, "R4");
        push(3'd0, 3'd0, 3'd0, 1'b0, "R4");
        push(3'd2, 3'd0, 3'd0, 1'b0, "R4");
        do_flush("R10");

        // R1, R11, R12: fill, stall drops input, refill on dispatch
        miss(3'd5, "R1");
        for (int i = 0; i < 4; i++) push(3'd0, 3'd5, 3'd0, 1'b0, "R1");
        push(3'd7, 3'd0, 3'd0, 1'b0, "R11");
        push(3'd6, 3'd0, 3'd0, 1'b0, "R11");
        for (int i = 0; i < 8; i++) push(3'd7, 3'd5, 3'd0, 1'b0, "R12");
        idle(4, "R12");

        // R10: flush with input offered and miss pending
        miss(3'd3, "R10");
        push(3'd4, 3'd3, 3'd0, 1'b0, "R10");
        step(1'b1, 3'd1, 3'd0, 3'd0, 1'b0, 1'b1, 1'b1, 3'd2, "R10");
        push(3'd6, 3'd3, 3'd2, 1'b0, "R10");
        idle(2, "R10");

        // R2: pseudo-random stream against the model
        x = 32'h1234_5678;
        for (int n = 0; n < 6000; n++) begin
            logic [2:0] a, b, c;
            x ^= x << 13; x ^= x >> 17; x ^= x << 5;
            a = {1'b0, x[1:0]} + {2'b0, x[20]};
            b = {1'b0, x[3:2]};
            c = x[21] ? {1'b0, x[5:4]} : 3'd0;
            step(x[7:6] != 2'b00, a, b, c, x[9:8] == 2'b00,
                 x[14:10] == 5'd0, x[18:15] == 4'd0, {1'b0, x[23:22]}, "R2");
        end
        summary();
    end
endmodule